// File: doc/BRIEF.md
# Nonvolatile Memory Command Controller

This block sequences commands against a small on-chip nonvolatile word array. The array is modelled as registers. Software reaches the block through a simple register bus, which gives it a command register, an address register, a 16-bit data register, a mode register, a status register and a 24-bit signature register. A command starts when a non-zero code is written to the command register while the block is idle. The block then stays busy for a programmable number of cycles, applies the command's effect at the end of that period, and reports success or failure in the status register. If the interrupt enable in the mode register is set, it also pulses an interrupt line.

The commands are word read, word write, erase-then-write, verify, page erase, mass erase, signature, protect and ping. Two safeguards limit what the commands can do. A write-enable bit in the mode register gates every command that alters the array. Mass erase spares a kernel region at the bottom of the array. The signature command walks the whole array and sums its words into the signature register. The busy periods stand in for real programming times and are scaled down for simulation. Bus offsets are: 0 command, 1 address, 2 data, 3 mode, 4 status, 5 signature. A read is `bus_sel` with `bus_wr` low, and its data is valid in the same cycle.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset, the command register reads 0x00, the mode register 0x80, and the status, data, address and signature registers 0; `irq` is low and every array word holds the erased value 0xFFFF.
- R2: Command code 0x01 (read) loads the data register with the array word at the address register.
- R3: Code 0x02 (write) stores the data register at the address. Code 0x03 (erase-then-write) first sets every word of the addressed page (PAGE_W = 3, so 8 words) to 0xFFFF and then stores the data register at the address.
- R4: Code 0x04 (verify) leaves the array unchanged. It sets status bit 0 when the addressed word equals the data register and status bit 1 when it differs.
- R5: Code 0x05 (page erase) sets the 8 words of the addressed page to 0xFFFF and leaves every other page unchanged.
- R6: Code 0x06 (mass erase) sets every word from address 8 upward to 0xFFFF and keeps the kernel words at addresses 0 to 7.
- R7: While mode bit 3 is 0, codes 0x02, 0x03, 0x05 and 0x06 leave the array unchanged and end with status bit 1 set.
- R8: Status bit 0 means the last command succeeded, bit 1 means it failed, and bit 2 means a command is busy. Bits 0 and 1 are never set together, and a read of the status register clears both.
- R9: A command stays busy for exactly its cycle count. The defaults are read 2, write 4, erase-then-write 12, verify 3, page erase 8, mass erase 20, protect 3, ping 2 and signature 64 (one per word). A refused or reserved command is busy for 1 cycle. A command write made while busy is ignored.
- R10: Once a command has completed, the command register reads 0x07.
- R11: When mode bit 4 is set, `irq` is high for exactly the one cycle in which the completion flags first show. When mode bit 4 is clear, `irq` stays low. Code 0x0F (ping) changes nothing and completes with status bit 0.
- R12: Code 0x0B (signature) writes the sum of all array words, modulo 2^24, to the signature register.
- R13: Code 0x0C (protect) succeeds once and then fails on each repeat until a mass erase completes. Codes other than 0x01 to 0x06, 0x0B, 0x0C and 0x0F fail.
- R14: Mode bits 7:5 always read 3'b100 and bit 2 always reads 0. Bits 4, 3 and 1:0 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 24 | Read data, valid in the access cycle |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions assume that `bus_sel` and `bus_wr` are clean levels, sampled only at the rising edge, and that any offset above 5 is simply ignored. They also assume software does not rely on the address or data register changing a command that is already running. The bench holds to this. It changes the bus only on falling edges, and it touches the address and data registers only between commands. The single exception is a deliberate command-register write during a busy period, which exercises the ignore rule.

// File: rtl/fcc_pkg.sv
// Shared definitions for the memory command controller.
// Assumes an 8-bit command code space and a six-register bus map.
package fcc_pkg;
    localparam logic [7:0] OP_NULL   = 8'h00;
    localparam logic [7:0] OP_READ   = 8'h01;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_ERWR   = 8'h03;
    localparam logic [7:0] OP_VERIFY = 8'h04;
    localparam logic [7:0] OP_PERASE = 8'h05;
    localparam logic [7:0] OP_MASS   = 8'h06;
    localparam logic [7:0] OP_SIGN   = 8'h0B;
    localparam logic [7:0] OP_PROT   = 8'h0C;
    localparam logic [7:0] OP_PING   = 8'h0F;
    localparam logic [7:0] CMD_AFTER = 8'h07;

    localparam logic [2:0] OFF_CMD = 3'd0;
    localparam logic [2:0] OFF_ADR = 3'd1;
    localparam logic [2:0] OFF_DAT = 3'd2;
    localparam logic [2:0] OFF_MOD = 3'd3;
    localparam logic [2:0] OFF_STS = 3'd4;
    localparam logic [2:0] OFF_SIG = 3'd5;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_SIGN = 2'd2
    } seq_state_e;
endpackage

// File: rtl/fcc_array.sv
// Word array that stands in for the nonvolatile cells.
// A write takes priority over an erase in the same cycle, which is how
// erase-then-write completes in one step. Mass erase spares the kernel pages.
// Assumes one command effect per cycle from the sequencer.
module fcc_array
    import fcc_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int PAGE_W       = 3,
    parameter int KERNEL_PAGES = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [15:0]              rd_data,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [15:0]              wr_data,
    input  logic                     pg_erase,
    input  logic [ADDR_W-PAGE_W-1:0] pg_idx,
    input  logic                     mass_erase
);
    localparam int DEPTH        = 1 << ADDR_W;
    localparam int KERNEL_WORDS = KERNEL_PAGES << PAGE_W;
    localparam int PG_W         = ADDR_W - PAGE_W;

    logic [15:0] mem [DEPTH];

    // Combinational read port.
    assign rd_data = mem[rd_addr];

    // Per-word update: reset to erased, then write, then erase.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n) begin
                mem[w] <= ERASED_WORD;
            end else if (wr_en && wr_addr == ADDR_W'(w)) begin
                mem[w] <= wr_data;
            end else if ((pg_erase && pg_idx == PG_W'(w >> PAGE_W)) ||
                         (mass_erase && w >= KERNEL_WORDS)) begin
                mem[w] <= ERASED_WORD;
            end
        end
    end

    // R6: a bare mass erase never touches the first kernel word.
    p_kernel_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mass_erase && !wr_en && !pg_erase) |=> $stable(mem[0]));

    // R5: erasing a page other than page 0 leaves word 0 alone.
    p_page_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_erase && !wr_en && !mass_erase && pg_idx != '0) |=> $stable(mem[0]));
endmodule

// File: rtl/fcc_timer.sv
// Down-counter that times a command's busy period.
// A load of N raises expire in the Nth cycle after the load.
// Assumes load_val is at least 1 whenever load is high.
module fcc_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero from the loaded value.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == CNT_W'(1)) && !load;

    // R9: once armed, the count drops by one each cycle until it is done.
    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CNT_W'(1) && !load) |=> (cnt_q != '0 && !expire) || cnt_q == CNT_W'(1));
endmodule

// File: rtl/flashcmd_ctrl.sv
// Command controller for an on-chip nonvolatile word array.
// Decodes bus accesses, starts a command when idle, times it with fcc_timer
// (or walks the array for a signature), and applies the effect at the end.
// Assumes single-cycle bus accesses and command operands that stay unchanged
// while a command runs. The operands are latched at start regardless.
module flashcmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int PAGE_W       = 3,
    parameter int KERNEL_PAGES = 1,
    parameter int CNT_W        = 16,
    parameter int RD_CYC       = 2,
    parameter int WR_CYC       = 4,
    parameter int EW_CYC       = 12,
    parameter int VF_CYC       = 3,
    parameter int PE_CYC       = 8,
    parameter int ME_CYC       = 20,
    parameter int PR_CYC       = 3,
    parameter int PG_CYC       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [23:0] bus_rdata,
    output logic        irq
);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    seq_state_e        state_q;
    logic [7:0]        cmd_q, op_q;
    logic [ADDR_W-1:0] addr_q, addr_l, sig_idx;
    logic [15:0]       data_q, data_l;
    logic              ie_q, we_q, we_l, rej_q, prot_used_q;
    logic [1:0]        ws_q;
    logic              done_q, fail_q, irq_q;
    logic [23:0]       sig_q, sig_acc;

    // Code classification helpers.
    function automatic logic code_known(input logic [7:0] c);
        return (c >= OP_READ && c <= OP_MASS) || c == OP_SIGN ||
               c == OP_PROT || c == OP_PING;
    endfunction

    function automatic logic code_alters(input logic [7:0] c);
        return c == OP_WRITE || c == OP_ERWR || c == OP_PERASE || c == OP_MASS;
    endfunction

    function automatic logic [CNT_W-1:0] code_cycles(input logic [7:0] c);
        case (c)
            OP_READ:   return CNT_W'(RD_CYC);
            OP_WRITE:  return CNT_W'(WR_CYC);
            OP_ERWR:   return CNT_W'(EW_CYC);
            OP_VERIFY: return CNT_W'(VF_CYC);
            OP_PERASE: return CNT_W'(PE_CYC);
            OP_MASS:   return CNT_W'(ME_CYC);
            OP_PROT:   return CNT_W'(PR_CYC);
            default:   return CNT_W'(PG_CYC);
        endcase
    endfunction

    logic busy, rd_en, wr_cmd, start, new_rej, t_load, t_expire;
    logic run_end, sig_end, finish, run_ok, vfy_bad, ok;
    logic arr_wr, arr_pg, arr_mass;
    logic [7:0]        new_code;
    logic [CNT_W-1:0]  t_val;
    logic [ADDR_W-1:0] arr_rd_addr;
    logic [15:0]       arr_rdata;

    // Bus decode and command start qualification.
    assign busy     = state_q != S_IDLE;
    assign rd_en    = bus_sel && !bus_wr;
    assign wr_cmd   = bus_sel && bus_wr && bus_addr == OFF_CMD;
    assign new_code = bus_wdata[7:0];
    assign start    = wr_cmd && !busy && new_code != OP_NULL;
    assign new_rej  = !code_known(new_code) || (code_alters(new_code) && !we_q) ||
                      (new_code == OP_PROT && prot_used_q);
    assign t_load   = start && !(new_code == OP_SIGN && !new_rej);
    assign t_val    = new_rej ? CNT_W'(1) : code_cycles(new_code);

    // Completion and effect strobes.
    assign run_end  = state_q == S_RUN && t_expire;
    assign sig_end  = state_q == S_SIGN && sig_idx == LAST_IDX;
    assign finish   = run_end || sig_end;
    assign run_ok   = run_end && !rej_q;
    assign vfy_bad  = op_q == OP_VERIFY && arr_rdata != data_l;
    assign ok       = sig_end || (run_ok && !vfy_bad);
    assign arr_wr   = run_ok && (op_q == OP_WRITE || op_q == OP_ERWR);
    assign arr_pg   = run_ok && (op_q == OP_ERWR || op_q == OP_PERASE);
    assign arr_mass = run_ok && op_q == OP_MASS;
    assign arr_rd_addr = (state_q == S_SIGN) ? sig_idx : addr_l;

    fcc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expire(t_expire)
    );

    fcc_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .KERNEL_PAGES(KERNEL_PAGES)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(arr_rd_addr), .rd_data(arr_rdata),
        .wr_en(arr_wr), .wr_addr(addr_l), .wr_data(data_l),
        .pg_erase(arr_pg), .pg_idx(addr_l[ADDR_W-1:PAGE_W]), .mass_erase(arr_mass)
    );

    // Sequencer: latch operands at start, walk the array for a signature.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NULL;
            addr_l  <= '0;
            data_l  <= '0;
            rej_q   <= 1'b0;
            we_l    <= 1'b0;
            sig_idx <= '0;
            sig_acc <= '0;
        end else if (start) begin
            state_q <= t_load ? S_RUN : S_SIGN;
            op_q    <= new_code;
            addr_l  <= addr_q;
            data_l  <= data_q;
            rej_q   <= new_rej;
            we_l    <= we_q;
            sig_idx <= '0;
            sig_acc <= '0;
        end else if (finish) begin
            state_q <= S_IDLE;
        end else if (state_q == S_SIGN) begin
            sig_idx <= sig_idx + 1'b1;
            sig_acc <= sig_acc + {8'h00, arr_rdata};
        end
    end

    // Command register: holds the written code, then the after-command code.
    always_ff @(posedge clk) begin
        if (!rst_n)                cmd_q <= OP_NULL;
        else if (finish)           cmd_q <= CMD_AFTER;
        else if (wr_cmd && !busy)  cmd_q <= new_code;
    end

    // Operand and mode registers; a read result overrides a bus data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            ie_q   <= 1'b0;
            we_q   <= 1'b0;
            ws_q   <= 2'b00;
        end else begin
            if (bus_sel && bus_wr && bus_addr == OFF_ADR) addr_q <= bus_wdata[ADDR_W-1:0];
            if (run_ok && op_q == OP_READ)
                data_q <= arr_rdata;
            else if (bus_sel && bus_wr && bus_addr == OFF_DAT)
                data_q <= bus_wdata;
            if (bus_sel && bus_wr && bus_addr == OFF_MOD) begin
                ie_q <= bus_wdata[4];
                we_q <= bus_wdata[3];
                ws_q <= bus_wdata[1:0];
            end
        end
    end

    // Completion flags, interrupt pulse, signature result and protect lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            irq_q       <= 1'b0;
            sig_q       <= '0;
            prot_used_q <= 1'b0;
        end else begin
            irq_q <= finish && ie_q;
            if (finish) begin
                done_q <= ok;
                fail_q <= !ok;
            end else if (rd_en && bus_addr == OFF_STS) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (sig_end) sig_q <= sig_acc + {8'h00, arr_rdata};
            if (run_ok && op_q == OP_PROT) prot_used_q <= 1'b1;
            else if (arr_mass)             prot_used_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            OFF_CMD: bus_rdata = {16'h0000, cmd_q};
            OFF_ADR: bus_rdata = 24'(addr_q);
            OFF_DAT: bus_rdata = {8'h00, data_q};
            OFF_MOD: bus_rdata = {16'h0000, 3'b100, ie_q, we_q, 1'b0, ws_q};
            OFF_STS: bus_rdata = {21'h0, busy, fail_q, done_q};
            OFF_SIG: bus_rdata = sig_q;
            default: bus_rdata = '0;
        endcase
    end

    // R8: success and failure are never reported together.
    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && fail_q));

    // R11: the interrupt only accompanies a fresh, idle completion.
    p_irq_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!busy && (done_q || fail_q)));

    // R10: leaving busy always leaves the after-command code behind.
    p_cmd_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cmd_q == CMD_AFTER);

    // R9: a command write during a busy period leaves the running op alone.
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd && !finish) |=> (busy && $stable(op_q) && $stable(addr_l)));

    // R7: the array is altered only when write enable was on at start.
    p_guarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr || arr_pg || arr_mass) |-> we_l);
endmodule

// File: tb/tb_flashcmd_ctrl.sv
module tb_flashcmd_ctrl;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic irq_s;
    logic irq_busy;
    logic [15:0] mdl [DEPTH];

    always #4 clk = ~clk;

    flashcmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] off, input logic [15:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off; bus_wdata = val;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] off, output logic [23:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off;
        #1 val = bus_rdata; irq_s = irq;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // Issue a command and poll status until idle; report busy reads and final status.
    task automatic run_cmd(input logic [7:0] code, output logic [23:0] sts, output int cyc);
        cyc = 0; irq_busy = 1'b0;
        bus_write(3'd0, {8'h00, code});
        for (int k = 0; k < 5000; k++) begin
            bus_read(3'd4, sts);
            if (!sts[2]) break;
            cyc++;
            if (irq_s) irq_busy = 1'b1;
        end
    endtask

    task automatic read_word(input int a, output logic [15:0] w);
        logic [23:0] s, d; int c;
        bus_write(3'd1, 16'(a));
        run_cmd(8'h01, s, c);
        bus_read(3'd2, d);
        w = d[15:0];
    endtask

    task automatic write_word(input int a, input logic [15:0] w);
        logic [23:0] s; int c;
        bus_write(3'd1, 16'(a));
        bus_write(3'd2, w);
        run_cmd(8'h02, s, c);
        mdl[a] = w;
    endtask

    task automatic t_reset;
        logic [23:0] v; logic [15:0] w;
        bus_read(3'd0, v); check("R1 cmd", v, 24'h0);
        bus_read(3'd3, v); check("R1 mode", v, 24'h80);
        bus_read(3'd4, v); check("R1 status", v, 24'h0);
        bus_read(3'd5, v); check("R1 sig", v, 24'h0);
        bus_read(3'd2, v); check("R1 data", v, 24'h0);
        check("R1 irq", {23'h0, irq}, 24'h0);
        bus_write(3'd3, 16'h0008);
        read_word(37, w); check("R1 erased word", {8'h0, w}, 24'hFFFF);
    endtask

    task automatic t_mode_bits;
        logic [23:0] v;
        bus_write(3'd3, 16'h00FF); bus_read(3'd3, v); check("R14 mode all ones", v, 24'h9B);
        bus_write(3'd3, 16'h0000); bus_read(3'd3, v); check("R14 mode cleared", v, 24'h80);
    endtask

    task automatic t_guard;
        logic [23:0] s; int c; logic [15:0] w;
        bus_write(3'd3, 16'h0000);
        bus_write(3'd1, 16'd5); bus_write(3'd2, 16'h1234);
        run_cmd(8'h02, s, c);
        check("R7 write refused fail", s, 24'h2);
        check("R9 refused busy 1", 24'(c), 24'd1);
        run_cmd(8'h06, s, c); check("R7 mass refused", s, 24'h2);
        bus_write(3'd3, 16'h0008);
        read_word(5, w); check("R7 word untouched", {8'h0, w}, 24'hFFFF);
    endtask

    task automatic t_write_read;
        logic [23:0] s; int c; logic [15:0] w;
        bus_write(3'd3, 16'h0008);
        bus_write(3'd1, 16'd3); bus_write(3'd2, 16'hA5C3);
        run_cmd(8'h02, s, c); mdl[3] = 16'hA5C3;
        check("R3 write ok", s, 24'h1);
        check("R9 write busy", 24'(c), 24'd4);
        bus_read(3'd4, s); check("R8 cleared on read", s, 24'h0);
        bus_read(3'd0, s); check("R10 cmd after", s, 24'h07);
        write_word(40, 16'h0F0F);
        write_word(63, 16'h8001);
        bus_write(3'd1, 16'd40);
        run_cmd(8'h01, s, c);
        check("R9 read busy", 24'(c), 24'd2);
        bus_read(3'd2, s); check("R2 read word 40", s, 24'h0F0F);
        read_word(3, w);  check("R2 read word 3", {8'h0, w}, 24'hA5C3);
        read_word(63, w); check("R2 read word 63", {8'h0, w}, 24'h8001);
    endtask

    task automatic t_verify;
        logic [23:0] s; int c;
        bus_write(3'd1, 16'd3); bus_write(3'd2, 16'hA5C3);
        run_cmd(8'h04, s, c);
        check("R4 verify match", s, 24'h1);
        check("R9 verify busy", 24'(c), 24'd3);
        bus_write(3'd2, 16'hA5C2);
        run_cmd(8'h04, s, c); check("R4 verify mismatch", s, 24'h2);
    endtask

    task automatic t_erwr;
        logic [23:0] s; int c; logic [15:0] w;
        write_word(9, 16'h1111); write_word(10, 16'h2222);
        bus_write(3'd1, 16'd10); bus_write(3'd2, 16'h3C3C);
        run_cmd(8'h03, s, c);
        for (int i = 8; i < 16; i++) mdl[i] = 16'hFFFF;
        mdl[10] = 16'h3C3C;
        check("R3 erase-write ok", s, 24'h1);
        check("R9 erase-write busy", 24'(c), 24'd12);
        read_word(9, w);  check("R3 page mate erased", {8'h0, w}, 24'hFFFF);
        read_word(10, w); check("R3 target written", {8'h0, w}, 24'h3C3C);
    endtask

    task automatic t_page_erase;
        logic [23:0] s; int c; logic [15:0] w;
        write_word(16, 16'h0001); write_word(23, 16'h0002); write_word(24, 16'h0003);
        bus_write(3'd1, 16'd19);
        run_cmd(8'h05, s, c);
        for (int i = 16; i < 24; i++) mdl[i] = 16'hFFFF;
        check("R9 page erase busy", 24'(c), 24'd8);
        read_word(16, w); check("R5 first of page", {8'h0, w}, 24'hFFFF);
        read_word(23, w); check("R5 last of page", {8'h0, w}, 24'hFFFF);
        read_word(24, w); check("R5 next page kept", {8'h0, w}, 24'h0003);
    endtask

    task automatic t_irq;
        logic [23:0] s; int c;
        bus_write(3'd3, 16'h0018);
        run_cmd(8'h0F, s, c);
        check("R11 ping done", s, 24'h1);
        check("R11 irq at end", {23'h0, irq_s}, 24'h1);
        check("R11 no irq while busy", {23'h0, irq_busy}, 24'h0);
        @(negedge clk); check("R11 irq one cycle", {23'h0, irq}, 24'h0);
        bus_write(3'd3, 16'h0008);
        run_cmd(8'h0F, s, c);
        check("R11 irq off", {23'h0, irq_s}, 24'h0);
        check("R9 ping busy", 24'(c), 24'd2);
    endtask

    task automatic t_signature;
        logic [23:0] s, exp; int c;
        exp = '0;
        for (int i = 0; i < DEPTH; i++) exp = exp + {8'h0, mdl[i]};
        run_cmd(8'h0B, s, c);
        check("R12 sign ok", s, 24'h1);
        check("R9 sign busy", 24'(c), 24'd64);
        bus_read(3'd5, s); check("R12 signature", s, exp);
    endtask

    task automatic t_reserved_busy;
        logic [23:0] s; int c;
        run_cmd(8'h07, s, c); check("R13 reserved 07", s, 24'h2);
        check("R9 reserved busy", 24'(c), 24'd1);
        run_cmd(8'h0A, s, c); check("R13 reserved 0A", s, 24'h2);
        // R9: a command write while busy is dropped
        bus_write(3'd1, 16'd30); bus_write(3'd2, 16'h7777);
        bus_write(3'd0, 16'h0002);
        bus_write(3'd0, 16'h0006);
        bus_read(3'd0, s); check("R9 cmd held while busy", s, 24'h02);
        for (int k = 0; k < 50; k++) begin
            bus_read(3'd4, s);
            if (!s[2]) break;
        end
        mdl[30] = 16'h7777;
        check("R9 first cmd completes", s, 24'h1);
    endtask

    task automatic t_protect_mass;
        logic [23:0] s; int c; logic [15:0] w;
        write_word(2, 16'hBEEF);
        run_cmd(8'h0C, s, c); check("R13 protect first", s, 24'h1);
        run_cmd(8'h0C, s, c); check("R13 protect repeat", s, 24'h2);
        run_cmd(8'h06, s, c);
        check("R6 mass ok", s, 24'h1);
        check("R9 mass busy", 24'(c), 24'd20);
        for (int i = 8; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        read_word(2, w);  check("R6 kernel kept", {8'h0, w}, 24'hBEEF);
        read_word(30, w); check("R6 user erased", {8'h0, w}, 24'hFFFF);
        read_word(8, w);  check("R6 first user erased", {8'h0, w}, 24'hFFFF);
        run_cmd(8'h0C, s, c); check("R13 protect after mass", s, 24'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_mode_bits();
        t_guard();
        t_write_read();
        t_verify();
        t_erwr();
        t_page_erase();
        t_irq();
        t_signature();
        t_reserved_busy();
        t_protect_mass();
        t_signature();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule